// File: doc/BRIEF.md
# Synchronous Memory Card Reset Sequencer

This block is the host-side engine that brings a 2-wire synchronous memory card out of power-off and reads its answer to reset. On a start strobe it switches on card power, waits until supply is good (a power-good input, optionally stretched by a programmable settle count), raises the card reset line, and issues a single card clock pulse while reset is high. Reset is then dropped. A burst of exactly 32 card clocks follows, and the card presents one answer bit in each of them.

The card clock is made from the system clock. Its high phase and its low phase each last one divider period, and that period has a floor of two system clocks. The block samples the card I/O line on every rising card clock of the answer burst and assembles a 32-bit answer word, first bit in bit 0. When the last bit is captured it pulses a done flag for one cycle. An I/O listen output marks the window in which the card is driving answer data. After completion, power stays on and the block rests until the next start or an abort. An abort switches the card fully off.

Top module: `scard_atr_seq`

## Requirements
- R1: After reset, card power, card reset, card clock, I/O listen, done and busy are all low and the answer word is zero.
- R2: A start accepted while idle raises card power on the next cycle. Card reset stays low while power-good is low, and it rises after exactly settle+1 consecutive cycles of power-good high. Card reset is never high without card power.
- R3: While card reset is high, exactly one card clock pulse is issued, and its rising edge comes P system cycles after card reset rises.
- R4: Card reset falls exactly P system cycles after the falling edge of the reset-phase clock pulse, with the card clock low.
- R5: After card reset falls, exactly 32 card clock pulses are issued, and then the card clock stays low.
- R6: The card clock idles low, and every high phase and every answer-burst low phase lasts exactly P = max(half-period setting, 2) system cycles. The setting is latched when start is accepted.
- R7: The I/O line is sampled at each rising card clock of the answer burst. The bit from the first answer clock lands in bit 0 of the answer word and the bit from the 32nd lands in bit 31.
- R8: Done is high for exactly one cycle, in the cycle that the 32nd answer clock rises. The answer word then holds its value until the next start is accepted.
- R9: I/O listen rises when card reset falls and drops on the falling edge of the 32nd answer clock. It is never high while card reset is high.
- R10: A start strobe while busy is ignored: the running sequence still produces exactly 32 answer clocks and the correct answer word.
- R11: An abort makes card power, card reset, card clock, I/O listen and busy all low on the next cycle.
- R12: After a completed sequence, busy is low, card power stays high, and a new start runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when not busy |
| abort_i | input | 1 | Synchronous abort; powers the card down |
| pwr_ok_i | input | 1 | Card supply is stable |
| half_per_i | input | DIV_W | Card clock half-period in system cycles (floor 2) |
| settle_i | input | SET_W | Extra cycles of power-good required before reset |
| card_io_i | input | 1 | Sampled card I/O line |
| card_pwr_o | output | 1 | Card power enable |
| card_rst_o | output | 1 | Card reset line |
| card_clk_o | output | 1 | Card clock line |
| io_listen_o | output | 1 | Card is driving answer data on I/O |
| atr_word_o | output | ATR_W | Answer word, first bit in bit 0 |
| atr_done_o | output | 1 | One-cycle pulse on capture of the last bit |
| busy_o | output | 1 | Sequence in progress |

## Verification
Every card-side output is a register, so each result appears in the cycle after the system edge that decides it. Power follows start by one cycle. Reset follows power-good by settle+1 cycles. Each clock phase lasts P cycles, the reset release lags the reset-phase clock fall by P, and done coincides with the 32nd answer rising edge. The bench drives inputs 2 ns after a rising edge and samples on the falling system edge. It measures each of these intervals as run lengths of sampled levels and compares them with values worked out from the settings: phase widths, the reset setup and release gaps, and the pre-reset power-good count. A card model in the bench moves to its next answer bit on each falling card clock, so the word it expects follows directly from bit order.

// File: rtl/scard_atr_pkg.sv
package scard_atr_pkg;

    localparam int ATR_BITS = 32;
    localparam int MIN_HALF = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POWER,
        ST_RST_SETUP,
        ST_RST_CLK_HI,
        ST_RST_CLK_LO,
        ST_ANS_LO,
        ST_ANS_HI,
        ST_SESSION
    } seq_state_e;

    typedef struct packed {
        logic pwr;
        logic rst;
        logic clk;
        logic listen;
    } card_pins_t;

    localparam card_pins_t PINS_OFF = '{pwr: 1'b0, rst: 1'b0, clk: 1'b0, listen: 1'b0};

    function automatic int unsigned eff_half(input int unsigned req);
        return (req < MIN_HALF) ? MIN_HALF : req;
    endfunction

    function automatic logic is_timed(input seq_state_e s);
        return (s == ST_RST_SETUP) || (s == ST_RST_CLK_HI) || (s == ST_RST_CLK_LO) ||
               (s == ST_ANS_LO) || (s == ST_ANS_HI);
    endfunction

endpackage

// File: rtl/scard_phase_timer.sv
module scard_phase_timer
    import scard_atr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic             run_i,
    output logic             ph_end_o
);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= DIV_W'(MIN_HALF);
        end else if (load_i) begin
            half_q <= DIV_W'(eff_half(32'(half_i)));
        end
    end

    assign ph_end_o = run_i && (cnt_q == (half_q - DIV_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (ph_end_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < half_q)) else $error("phase counter beyond period"); // R6
    AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (rst)
        half_q >= DIV_W'(MIN_HALF)) else $error("period below floor"); // R6

endmodule

// File: rtl/scard_settle.sv
module scard_settle #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             pwr_ok_i,
    input  logic [SET_W-1:0] settle_i,
    output logic             ready_o
);

    logic [SET_W-1:0] cnt_q;

    assign ready_o = arm_i && pwr_ok_i && (cnt_q == settle_i);

    always_ff @(posedge clk) begin
        if (rst || !arm_i || !pwr_ok_i) begin
            cnt_q <= '0;
        end else if (!ready_o) begin
            cnt_q <= cnt_q + SET_W'(1);
        end
    end

endmodule

// File: rtl/scard_atr_shreg.sv
module scard_atr_shreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            data_q <= '0;
        end else if (shift_i) begin
            data_q <= {bit_i, data_q[W-1:1]};
        end
    end

    assign data_o = data_q;

    AST_ATR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift_i && !clear_i) |=> $stable(data_q)) else $error("answer word moved"); // R8

endmodule

// File: rtl/scard_atr_fsm.sv
module scard_atr_fsm
    import scard_atr_pkg::*;
#(
    parameter int ATR_W = ATR_BITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       abort_i,
    input  logic       settle_ok_i,
    input  logic       ph_end_i,
    output card_pins_t pins_o,
    output logic       run_o,
    output logic       arm_o,
    output logic       load_o,
    output logic       shift_o,
    output logic       done_o,
    output logic       busy_o
);

    localparam int CNT_W = (ATR_W > 1) ? $clog2(ATR_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ATR_W - 1);

    seq_state_e       state_q;
    card_pins_t       pins_q;
    logic [CNT_W-1:0] bit_q;
    logic             done_q;
    logic             resting;

    assign resting = (state_q == ST_IDLE) || (state_q == ST_SESSION);
    assign load_o  = resting && start_i && !abort_i;
    assign run_o   = is_timed(state_q);
    assign arm_o   = (state_q == ST_POWER);
    assign shift_o = (state_q == ST_ANS_LO) && ph_end_i && !abort_i;
    assign busy_o  = !resting;
    assign pins_o  = pins_q;
    assign done_o  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= PINS_OFF;
            bit_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort_i) begin
                state_q <= ST_IDLE;
                pins_q  <= PINS_OFF;
                bit_q   <= '0;
            end else begin
                case (state_q)
                    ST_IDLE, ST_SESSION: begin
                        if (start_i) begin
                            state_q     <= ST_POWER;
                            pins_q      <= PINS_OFF;
                            pins_q.pwr  <= 1'b1;
                            bit_q       <= '0;
                        end
                    end
                    ST_POWER: begin
                        if (settle_ok_i) begin
                            pins_q.rst <= 1'b1;
                            state_q    <= ST_RST_SETUP;
                        end
                    end
                    ST_RST_SETUP: begin
                        if (ph_end_i) begin
                            pins_q.clk <= 1'b1;
                            state_q    <= ST_RST_CLK_HI;
                        end
                    end
                    ST_RST_CLK_HI: begin
                        if (ph_end_i) begin
                            pins_q.clk <= 1'b0;
                            state_q    <= ST_RST_CLK_LO;
                        end
                    end
                    ST_RST_CLK_LO: begin
                        if (ph_end_i) begin
                            pins_q.rst    <= 1'b0;
                            pins_q.listen <= 1'b1;
                            state_q       <= ST_ANS_LO;
                        end
                    end
                    ST_ANS_LO: begin
                        if (ph_end_i) begin
                            pins_q.clk <= 1'b1;
                            state_q    <= ST_ANS_HI;
                            if (bit_q == LAST_BIT) begin
                                done_q <= 1'b1;
                            end
                        end
                    end
                    ST_ANS_HI: begin
                        if (ph_end_i) begin
                            pins_q.clk <= 1'b0;
                            if (bit_q == LAST_BIT) begin
                                pins_q.listen <= 1'b0;
                                state_q       <= ST_SESSION;
                            end else begin
                                bit_q   <= bit_q + CNT_W'(1);
                                state_q <= ST_ANS_LO;
                            end
                        end
                    end
                    default: begin
                        state_q <= ST_IDLE;
                        pins_q  <= PINS_OFF;
                    end
                endcase
            end
        end
    end

    AST_RST_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        pins_q.rst |-> pins_q.pwr) else $error("reset without power"); // R2
    AST_RST_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.rst) |-> (!pins_q.clk && $past(!pins_q.clk))) else $error("reset released near clock"); // R4
    AST_CLK_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
        ($rose(pins_q.clk) && !abort_i) |=> pins_q.clk) else $error("clock high too short"); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done longer than one cycle"); // R8
    AST_LISTEN_NO_RST: assert property (@(posedge clk) disable iff (rst)
        pins_q.listen |-> !pins_q.rst) else $error("listen during reset"); // R9
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!pins_q.pwr && !pins_q.rst && !pins_q.clk && !pins_q.listen && resting))
        else $error("abort left card active"); // R11

endmodule

// File: rtl/scard_atr_seq.sv
module scard_atr_seq
    import scard_atr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SET_W = 8,
    parameter int ATR_W = ATR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             pwr_ok_i,
    input  logic [DIV_W-1:0] half_per_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic             card_io_i,
    output logic             card_pwr_o,
    output logic             card_rst_o,
    output logic             card_clk_o,
    output logic             io_listen_o,
    output logic [ATR_W-1:0] atr_word_o,
    output logic             atr_done_o,
    output logic             busy_o
);

    card_pins_t pins;
    logic       run, arm, load, shift, ph_end, settle_ok;

    scard_atr_fsm #(.ATR_W(ATR_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .abort_i     (abort_i),
        .settle_ok_i (settle_ok),
        .ph_end_i    (ph_end),
        .pins_o      (pins),
        .run_o       (run),
        .arm_o       (arm),
        .load_o      (load),
        .shift_o     (shift),
        .done_o      (atr_done_o),
        .busy_o      (busy_o)
    );

    scard_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .half_i   (half_per_i),
        .run_i    (run),
        .ph_end_o (ph_end)
    );

    scard_settle #(.SET_W(SET_W)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (arm),
        .pwr_ok_i (pwr_ok_i),
        .settle_i (settle_i),
        .ready_o  (settle_ok)
    );

    scard_atr_shreg #(.W(ATR_W)) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .clear_i (load),
        .shift_i (shift),
        .bit_i   (card_io_i),
        .data_o  (atr_word_o)
    );

    assign card_pwr_o  = pins.pwr;
    assign card_rst_o  = pins.rst;
    assign card_clk_o  = pins.clk;
    assign io_listen_o = pins.listen;

endmodule

// File: tb/tb_scard_atr_seq.sv
module tb_scard_atr_seq;

    localparam int DIV_W = 8;
    localparam int SET_W = 8;
    localparam int ATR_W = 32;

    logic clk = 1'b0;
    logic rst;
    logic start_i, abort_i, pwr_ok_i;
    logic [DIV_W-1:0] half_per_i;
    logic [SET_W-1:0] settle_i;
    logic card_io_i;
    logic card_pwr_o, card_rst_o, card_clk_o, io_listen_o, atr_done_o, busy_o;
    logic [ATR_W-1:0] atr_word_o;

    always #5 clk = ~clk;

    scard_atr_seq #(.DIV_W(DIV_W), .SET_W(SET_W), .ATR_W(ATR_W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i), .pwr_ok_i(pwr_ok_i),
        .half_per_i(half_per_i), .settle_i(settle_i), .card_io_i(card_io_i),
        .card_pwr_o(card_pwr_o), .card_rst_o(card_rst_o), .card_clk_o(card_clk_o),
        .io_listen_o(io_listen_o), .atr_word_o(atr_word_o), .atr_done_o(atr_done_o),
        .busy_o(busy_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // card model and monitor state
    logic [31:0] exp_word = 32'h0;
    int  idx = 0;
    logic p_clk, p_rst, p_listen;
    int  hi_cnt, lo_cnt, rs_cnt;
    int  rst_rises, ans_rises, setup_gap, rst_gap, pre_rst;
    int  hi_min, hi_max, lo_min, lo_max;
    int  done_seen, done_at, listen_falls;
    logic done_clk, listen_bad, rst_no_pwr, seen_rst;

    assign card_io_i = (idx < 32) ? exp_word[idx] : 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic mon_clear();
        p_clk = card_clk_o; p_rst = card_rst_o; p_listen = io_listen_o;
        hi_cnt = 0; lo_cnt = 0; rs_cnt = 0;
        rst_rises = 0; ans_rises = 0; setup_gap = -1; rst_gap = -1; pre_rst = 0;
        hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
        done_seen = 0; done_at = -1; listen_falls = 0;
        done_clk = 1'b0; listen_bad = 1'b0; rst_no_pwr = 1'b0; seen_rst = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (card_clk_o && !p_clk) begin
                if (card_rst_o) begin
                    rst_rises++;
                    setup_gap = rs_cnt;
                end else if (io_listen_o) begin
                    if (ans_rises > 0) begin
                        if (lo_cnt < lo_min) lo_min = lo_cnt;
                        if (lo_cnt > lo_max) lo_max = lo_cnt;
                    end
                    ans_rises++;
                end
            end
            if (!card_clk_o && p_clk) begin
                if (hi_cnt < hi_min) hi_min = hi_cnt;
                if (hi_cnt > hi_max) hi_max = hi_cnt;
                if (!card_rst_o) idx++;
            end
            if (p_listen && !io_listen_o) begin
                listen_falls++;
                if (!(p_clk && !card_clk_o)) listen_bad = 1'b1;
            end
            if (io_listen_o && card_rst_o) listen_bad = 1'b1;
            if (p_rst && !card_rst_o) rst_gap = lo_cnt;
            if (card_rst_o && !p_rst) idx = 0;
            if (card_rst_o && !card_pwr_o) rst_no_pwr = 1'b1;
            if (busy_o && pwr_ok_i && card_pwr_o && !card_rst_o && !seen_rst) pre_rst++;
            if (card_rst_o) seen_rst = 1'b1;
            if (card_rst_o && !card_clk_o && rst_rises == 0) rs_cnt++;
            if (atr_done_o) begin
                done_seen++;
                done_at = ans_rises;
                done_clk = card_clk_o;
            end
            hi_cnt = card_clk_o ? hi_cnt + 1 : 0;
            lo_cnt = card_clk_o ? 0 : lo_cnt + 1;
            p_clk = card_clk_o; p_rst = card_rst_o; p_listen = io_listen_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0; abort_i = 1'b0; pwr_ok_i = 1'b1;
        half_per_i = '0; settle_i = '0;
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk); #2;
        chk({card_pwr_o, card_rst_o, card_clk_o, io_listen_o, atr_done_o, busy_o} == 6'b0,
            "R1", "outputs after reset",
            {card_pwr_o, card_rst_o, card_clk_o, io_listen_o, atr_done_o, busy_o}, 0);
        chk(atr_word_o == 32'h0, "R1", "answer word after reset", atr_word_o, 0);
        mon_clear();
    endtask

    // one full session; hold_low keeps power-good low for a while, poke strobes start mid-run
    task automatic run_session(input int half, input int settle, input logic [31:0] word,
                               input bit hold_low, input bit poke);
        int p;
        bit poked;
        p = (half < 2) ? 2 : half;
        poked = 1'b0;
        half_per_i = DIV_W'(half);
        settle_i = SET_W'(settle);
        exp_word = word;
        if (hold_low) pwr_ok_i = 1'b0;
        mon_clear();
        @(posedge clk); #2 start_i = 1'b1;
        @(posedge clk); #2 start_i = 1'b0;
        chk(card_pwr_o == 1'b1 && busy_o == 1'b1, "R2", "power one cycle after start",
            {card_pwr_o, busy_o}, 2'b11);
        if (hold_low) begin
            repeat (15) @(posedge clk);
            #2;
            chk(card_rst_o == 1'b0 && card_pwr_o == 1'b1, "R2", "reset held while power not good",
                card_rst_o, 0);
            pwr_ok_i = 1'b1;
        end
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk); #2;
            start_i = 1'b0;
            if (poke && !poked && ans_rises == 5) begin
                start_i = 1'b1;
                poked = 1'b1;
            end
            if (!busy_o && !start_i) break;
        end
        repeat (3) @(posedge clk);
        #2;
        chk(pre_rst == settle + 1, "R2", "power-good cycles before reset", pre_rst, settle + 1);
        chk(!rst_no_pwr, "R2", "reset only with power", rst_no_pwr, 0);
        chk(rst_rises == 1, "R3", "clock pulses during reset", rst_rises, 1);
        chk(setup_gap == p, "R3", "reset to first clock gap", setup_gap, p);
        chk(rst_gap == p, "R4", "clock fall to reset release", rst_gap, p);
        chk(ans_rises == 32, "R5", "answer clocks", ans_rises, 32);
        chk(hi_min == p && hi_max == p, "R6", "clock high width", hi_max, p);
        chk(lo_min == p && lo_max == p, "R6", "clock low width", lo_max, p);
        chk(card_clk_o == 1'b0, "R6", "clock idles low", card_clk_o, 0);
        chk(atr_word_o == word, "R7", "answer word lsb first", atr_word_o, word);
        chk(done_seen == 1, "R8", "done pulse length", done_seen, 1);
        chk(done_at == 32 && done_clk, "R8", "done on last rising clock", done_at, 32);
        chk(listen_falls == 1 && !listen_bad, "R9", "listen window", listen_falls, 1);
        chk(card_pwr_o == 1'b1 && busy_o == 1'b0, "R12", "session rests powered",
            {card_pwr_o, busy_o}, 2'b10);
        if (poke) begin
            chk(poked && ans_rises == 32 && atr_word_o == word, "R10", "start while busy ignored",
                ans_rises, 32);
        end
        repeat (12) @(posedge clk);
        #2;
        chk(atr_word_o == word, "R8", "answer word held", atr_word_o, word);
    endtask

    task automatic t_abort();
        half_per_i = DIV_W'(3);
        settle_i = SET_W'(1);
        exp_word = 32'h1234_5678;
        mon_clear();
        @(posedge clk); #2 start_i = 1'b1;
        @(posedge clk); #2 start_i = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); #2;
            if (ans_rises >= 10) break;
        end
        abort_i = 1'b1;
        @(posedge clk); #2 abort_i = 1'b0;
        chk({card_pwr_o, card_rst_o, card_clk_o, io_listen_o, busy_o} == 5'b0, "R11",
            "outputs after abort", {card_pwr_o, card_rst_o, card_clk_o, io_listen_o, busy_o}, 0);
        repeat (6) @(posedge clk);
        #2;
        chk({card_pwr_o, card_clk_o, busy_o} == 3'b0, "R11", "stays off after abort",
            {card_pwr_o, card_clk_o, busy_o}, 0);
    endtask

    initial begin
        t_reset();
        run_session(3, 0, 32'hA5C3_0F12, 1'b0, 1'b0);
        run_session(5, 4, 32'h8000_0001, 1'b1, 1'b0);
        run_session(0, 2, 32'hFFFF_0000, 1'b0, 1'b1);
        t_abort();
        run_session(2, 0, 32'h0000_0001, 1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule